// File: doc/BRIEF.md
# Programmable-Frame Serial Transceiver

This block is a full-duplex asynchronous serial port. A processor controls it through a small 32-bit register bus with word-aligned byte offsets. Characters written to the transmit data register queue in an 8-entry FIFO, and the serializer sends them on `ser_tx`. Characters recovered from `ser_rx` queue in a second 8-entry FIFO, and a read of the receive data register removes them.

Bit timing is a direct count of clock cycles per bit, with no fixed oversampling ratio. A second register chooses the cycle within each bit at which the receiver samples the line. The frame shape is set by software: 5 to 8 data bits sent least significant bit first, optional even or odd parity, and one or two stop bits.

Seven sticky event flags record FIFO conditions and receive errors. A per-flag enable mask combines them into one interrupt line.

Top module: `ser_xcvr`

## Requirements
- R1: After reset, `ser_tx` is high, `irq` is low, and the status word at offset 0x18 reads 0xA. In that word, bit 3 is TX empty, bit 2 is TX full, bit 1 is RX empty and bit 0 is RX full.
- R2: The control word at offset 0x00 reads back as written. Its fields are:
  - bits 31:8: cycles per bit;
  - bit 7: master enable;
  - bit 6: receiver on;
  - bit 5: transmitter on;
  - bit 4: parity on;
  - bit 3: parity odd when 1, even when 0;
  - bit 2: two stop bits when 1;
  - bits 1:0: data length minus 5.

  The sample-offset word at offset 0x08 also reads back as written.
- R3: Each queued character is sent as one frame, and every bit of it lasts the programmed number of cycles. The frame is a low start bit, then the data bits LSB first, then the parity bit if parity is on, then one or two high stop bits.
- R4: The parity bit makes the count of ones over the data and parity bits even when bit 3 is 0 and odd when bit 3 is 1.
- R5: A received frame of any length and format is stored zero-extended. Each bit is taken at the programmed sample offset. A read of offset 0x14 returns the oldest stored character in bits 7:0 and removes it.
- R6: A low pulse on `ser_rx` that is high again at the start bit's sample point is discarded, and nothing is stored.
- R7: A wrong parity bit sets event bit 2, and a low stop bit sets event bit 1. The character is still stored.
- R8: Each FIFO holds 8 characters. A received character that arrives while the RX FIFO is full is dropped and sets event bit 3. A write to offset 0x10 while the TX FIFO is full is dropped and sets event bit 0.
- R9: A read of offset 0x14 while the RX FIFO is empty returns 0 and sets event bit 4.
- R10: The event flags are sticky and read at offset 0x2C. Bit 6 is set while the RX FIFO is not empty, and bit 5 while the TX FIFO is empty. Writing 1 to a bit at offset 0x24 clears that flag. `irq` is the OR of the flags ANDed with the mask at offset 0x1C.
- R11: Turning the transmitter off lets the frame in progress finish. After that, `ser_tx` stays high and the queued characters remain in the TX FIFO.
- R12: Turning the receiver off returns it to idle at once, so a partly received frame is never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX data at 0x14) |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| ser_rx | input | 1 | Serial line in |
| ser_tx | output | 1 | Serial line out |
| irq | output | 1 | Masked interrupt |

## Verification
The bench loops through all 24 combinations of length, parity mode and stop count. For each one it sends a character out through the transmitter and one in through the receiver, each a different byte value. The transmit side shows that bit order, length and parity sense are applied. The receive side shows that characters shorter than 8 bits are zero-extended and that correct frames raise no error flag. Further patterns cover a short glitch, a bad parity bit, a low stop bit, and a burst of nine frames against the FIFO depth. They also cover turning each direction off part-way through a frame, which separates a finished frame from one that is cut short or wrongly accepted.

// File: rtl/ser_pkg.sv
package ser_pkg;
   typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} phase_e;

   typedef struct packed {
      logic       par_en;
      logic       par_odd;
      logic       two_stop;
      logic [1:0] len;      // data bits minus 5
   } fmt_t;

   // word indices (byte address / 4)
   localparam logic [3:0] W_CTRL  = 4'h0;
   localparam logic [3:0] W_SAMP  = 4'h2;
   localparam logic [3:0] W_TXD   = 4'h4;
   localparam logic [3:0] W_RXD   = 4'h5;
   localparam logic [3:0] W_STAT  = 4'h6;
   localparam logic [3:0] W_MASK  = 4'h7;
   localparam logic [3:0] W_CLR   = 4'h9;
   localparam logic [3:0] W_EVT   = 4'hB;

   localparam int NUM_EVT = 7;
endpackage

// File: rtl/ser_fifo.sv
module ser_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ser_fifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         if (do_push && !do_pop)      cnt <= cnt + (AW+1)'(1);
         else if (do_pop && !do_push) cnt <= cnt - (AW+1)'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   a_r8_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/ser_tx.sv
module ser_tx
   import ser_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] period,
   input  fmt_t             fmt,
   input  logic             have,
   input  logic [7:0]       din,
   output logic             pop,
   output logic             txd
);
   phase_e           st;
   logic [CNT_W-1:0] cyc;
   logic [2:0]       idx;
   logic [7:0]       sh;
   logic             par, second;
   logic             last;
   logic [2:0]       last_idx;

   assign last     = (cyc == period - CNT_W'(1));
   assign last_idx = {1'b1, fmt.len};
   assign pop      = (st == PH_IDLE) && run && have;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= PH_IDLE; cyc <= '0; idx <= '0; sh <= '0;
         par <= 1'b0; second <= 1'b0; txd <= 1'b1;
      end else if (st == PH_IDLE) begin
         txd <= 1'b1;
         if (pop) begin
            st <= PH_START; txd <= 1'b0; cyc <= '0;
            sh <= din; par <= fmt.par_odd; idx <= '0; second <= 1'b0;
         end
      end else begin
         cyc <= last ? '0 : cyc + CNT_W'(1);
         if (last) begin
            unique case (st)
               PH_START: begin
                  st <= PH_DATA; txd <= sh[0]; par <= par ^ sh[0]; sh <= sh >> 1;
               end
               PH_DATA: begin
                  if (idx == last_idx) begin
                     if (fmt.par_en) begin st <= PH_PAR; txd <= par; end
                     else            begin st <= PH_STOP; txd <= 1'b1; end
                  end else begin
                     idx <= idx + 3'd1; txd <= sh[0]; par <= par ^ sh[0]; sh <= sh >> 1;
                  end
               end
               PH_PAR:  begin st <= PH_STOP; txd <= 1'b1; end
               PH_STOP: begin
                  txd <= 1'b1;
                  if (fmt.two_stop && !second) second <= 1'b1;
                  else                         st <= PH_IDLE;
               end
               default: st <= PH_IDLE;
            endcase
         end
      end
   end

   a_r3_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_IDLE) |-> txd);
   a_r11_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_IDLE && !run) |=> (st == PH_IDLE));
endmodule

// File: rtl/ser_rx.sv
module ser_rx
   import ser_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] samp,
   input  fmt_t             fmt,
   input  logic             rxd,
   output logic             push,
   output logic [7:0]       dout,
   output logic             perr,
   output logic             serr
);
   phase_e           st;
   logic [CNT_W-1:0] cyc;
   logic [2:0]       idx;
   logic             s1, s2, s3, par, second;
   logic             last, at_samp;
   logic [2:0]       last_idx;

   assign last     = (cyc == period - CNT_W'(1));
   assign at_samp  = (cyc == samp);
   assign last_idx = {1'b1, fmt.len};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
         st <= PH_IDLE; cyc <= '0; idx <= '0; dout <= '0;
         par <= 1'b0; second <= 1'b0; perr <= 1'b0; serr <= 1'b0; push <= 1'b0;
      end else begin
         s1 <= rxd; s2 <= s1; s3 <= s2;
         push <= 1'b0;
         if (!run) begin
            st <= PH_IDLE;
         end else if (st == PH_IDLE) begin
            if (s3 && !s2) begin
               st <= PH_START; cyc <= '0; idx <= '0; dout <= '0;
               par <= fmt.par_odd; second <= 1'b0; perr <= 1'b0; serr <= 1'b0;
            end
         end else begin
            cyc <= last ? '0 : cyc + CNT_W'(1);
            unique case (st)
               PH_START: begin
                  if (at_samp && s2) st <= PH_IDLE;
                  else if (last)     st <= PH_DATA;
               end
               PH_DATA: begin
                  if (at_samp) begin dout[idx] <= s2; par <= par ^ s2; end
                  if (last) begin
                     if (idx == last_idx) st <= fmt.par_en ? PH_PAR : PH_STOP;
                     else                 idx <= idx + 3'd1;
                  end
               end
               PH_PAR: begin
                  if (at_samp) perr <= par ^ s2;
                  if (last)    st <= PH_STOP;
               end
               PH_STOP: begin
                  if (at_samp) begin
                     serr <= serr | ~s2;
                     if (!(fmt.two_stop && !second)) begin
                        push <= 1'b1; st <= PH_IDLE;
                     end
                  end
                  if (last) second <= 1'b1;
               end
               default: st <= PH_IDLE;
            endcase
         end
      end
   end

   a_r12_off_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (st == PH_IDLE));
   a_r5_push_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> ($past(st) == PH_STOP));
endmodule

// File: rtl/ser_xcvr.sv
module ser_xcvr
   import ser_pkg::*;
#(
   parameter int CNT_W  = 24,
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ser_rx,
   output logic              ser_tx,
   output logic              irq
);
   generate
      if (CNT_W < 4 || CNT_W > 24) begin : g_bad_cnt
         $error("ser_xcvr: CNT_W must be 4..24");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ser_xcvr: ADDR_W must be >= 6");
      end
   endgenerate

   logic [31:0]        ctrl;
   logic [CNT_W-1:0]   samp;
   logic [NUM_EVT-1:0] mask, flags, ev, clr;
   logic [3:0]         widx;
   fmt_t               fmt;
   logic               tx_push, tx_pop, tx_empty, tx_full;
   logic               rx_push, rx_pop, rx_empty, rx_full, perr, serr;
   logic [7:0]         tx_head, rx_head, rx_char;
   logic               unused_lsb;

   assign unused_lsb = ^bus_addr[1:0];
   assign widx    = bus_addr[5:2];
   assign fmt     = fmt_t'(ctrl[4:0]);
   assign tx_push = bus_wr && (widx == W_TXD);
   assign rx_pop  = bus_rd && (widx == W_RXD);

   ser_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
      .clk, .rst_n, .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop),
      .head(tx_head), .empty(tx_empty), .full(tx_full));

   ser_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
      .clk, .rst_n, .push(rx_push), .din(rx_char), .pop(rx_pop),
      .head(rx_head), .empty(rx_empty), .full(rx_full));

   ser_tx #(.CNT_W(CNT_W)) u_tx (
      .clk, .rst_n, .run(ctrl[7] & ctrl[5]), .period(ctrl[8 +: CNT_W]), .fmt,
      .have(!tx_empty), .din(tx_head), .pop(tx_pop), .txd(ser_tx));

   ser_rx #(.CNT_W(CNT_W)) u_rx (
      .clk, .rst_n, .run(ctrl[7] & ctrl[6]), .period(ctrl[8 +: CNT_W]), .samp, .fmt,
      .rxd(ser_rx), .push(rx_push), .dout(rx_char), .perr, .serr);

   assign ev  = {!rx_empty, tx_empty, rx_pop && rx_empty, rx_push && rx_full,
                 rx_push && perr, rx_push && serr, tx_push && tx_full};
   assign clr = (bus_wr && widx == W_CLR) ? bus_wdata[NUM_EVT-1:0] : '0;
   assign irq = |(flags & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl  <= '0;
         samp  <= '0;
         mask  <= '0;
         flags <= '0;
      end else begin
         if (bus_wr && widx == W_CTRL) ctrl <= bus_wdata;
         if (bus_wr && widx == W_SAMP) samp <= bus_wdata[CNT_W-1:0];
         if (bus_wr && widx == W_MASK) mask <= bus_wdata[NUM_EVT-1:0];
         flags <= (flags & ~clr) | ev;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (widx)
         W_CTRL: bus_rdata = ctrl;
         W_SAMP: bus_rdata[CNT_W-1:0] = samp;
         W_RXD:  bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
         W_STAT: bus_rdata[3:0] = {tx_empty, tx_full, rx_empty, rx_full};
         W_MASK: bus_rdata[NUM_EVT-1:0] = mask;
         W_EVT:  bus_rdata[NUM_EVT-1:0] = flags;
         default: bus_rdata = '0;
      endcase
   end

   a_r9_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && rx_empty) |=> flags[4]);
   a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && widx == W_CLR && bus_wdata[3] && !(rx_push && rx_full)) |=> !flags[3]);
   a_r8_tx_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> $past(tx_push && tx_full));
endmodule

// File: tb/tb_ser_xcvr.sv
module tb_ser_xcvr;
   localparam logic [5:0] A_CTRL = 6'd0,  A_SAMP = 6'd8,  A_TXD = 6'd16, A_RXD = 6'd20;
   localparam logic [5:0] A_STAT = 6'd24, A_MASK = 6'd28, A_CLR = 6'd36, A_EVT = 6'd44;
   localparam int BIT = 16;

   logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, ser_rx = 1'b1;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic ser_tx, irq;
   int nchk = 0, nfail = 0;

   always #4 clk = ~clk;

   ser_xcvr dut (.clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
                 .ser_rx, .ser_tx, .irq);

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic ctl(input int len, input bit pe, input bit po, input bit two,
                      input bit rxon, input bit txon);
      wr(A_CTRL, {24'(BIT), 1'b1, rxon, txon, pe, po, two, 2'(len)});
   endtask

   function automatic logic [7:0] cmask(input int len);
      return 8'((1 << (len + 5)) - 1);
   endfunction

   task automatic wait_start(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (ser_tx === 1'b0) begin ok = 1'b1; break; end
      end
      if (!ok) check(1, 0, "R3 no start bit seen");
   endtask

   // call right after the falling edge was seen; pre = negedges already spent
   task automatic tx_frame(input logic [7:0] v, input int len, input bit pe, input bit po,
                           input bit two, input int pre);
      logic [7:0] got = '0;
      repeat (BIT/2 - pre) @(negedge clk);
      check(ser_tx, 0, "R3 start bit");
      for (int i = 0; i < len + 5; i++) begin
         repeat (BIT) @(negedge clk);
         got[i] = ser_tx;
      end
      check(got, v & cmask(len), "R3 data bits LSB first");
      if (pe) begin
         repeat (BIT) @(negedge clk);
         check(ser_tx, ^(v & cmask(len)) ^ po, "R4 parity bit");
      end
      repeat (BIT) @(negedge clk);
      check(ser_tx, 1, "R3 stop bit");
      if (two) begin
         repeat (BIT) @(negedge clk);
         check(ser_tx, 1, "R3 second stop bit");
      end
   endtask

   task automatic rx_send(input logic [7:0] v, input int len, input bit pe, input bit po,
                          input bit two, input bit badpar, input logic stopv);
      @(negedge clk); ser_rx = 1'b0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < len + 5; i++) begin
         ser_rx = v[i];
         repeat (BIT) @(negedge clk);
      end
      if (pe) begin
         ser_rx = ^(v & cmask(len)) ^ po ^ badpar;
         repeat (BIT) @(negedge clk);
      end
      ser_rx = stopv;
      repeat (BIT) @(negedge clk);
      ser_rx = 1'b1;
      if (two) repeat (BIT) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(0, 1, "watchdog expired");
      report();
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [7:0]  v;
      bit          ok;
      int          k = 0, lows;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(ser_tx, 1, "R1 line idle high");
      check(irq, 0, "R1 irq low");
      rd(A_STAT, d);
      check(d, 32'hA, "R1 status after reset");

      wr(A_CTRL, 32'hABCDE_F5A);
      rd(A_CTRL, d);
      check(d, 32'hABCDE_F5A, "R2 control readback");
      wr(A_SAMP, BIT/2);
      rd(A_SAMP, d);
      check(d, BIT/2, "R2 sample offset readback");

      // sweep every frame format
      for (int len = 0; len < 4; len++)
         for (int pm = 0; pm < 3; pm++)
            for (int two = 0; two < 2; two++) begin
               v = 8'h5A + 8'(k * 29); k++;
               ctl(len, pm != 0, pm == 2, two[0], 1'b1, 1'b1);
               wr(A_TXD, {24'd0, v});
               wait_start(ok);
               if (ok) tx_frame(v, len, pm != 0, pm == 2, two[0], 0);
               repeat (BIT) @(negedge clk);
               v = ~v + 8'd3;
               rx_send(v, len, pm != 0, pm == 2, two[0], 1'b0, 1'b1);
               rd(A_RXD, d);
               check(d, {24'd0, v & cmask(len)}, "R5 received char zero-extended");
               rd(A_EVT, d);
               check(d & 32'h1E, 0, "R7 no error on good frame");
               wr(A_CLR, 32'h7F);
            end

      // glitch
      ctl(3, 0, 0, 0, 1, 1);
      @(negedge clk); ser_rx = 1'b0;
      repeat (3) @(negedge clk); ser_rx = 1'b1;
      repeat (60) @(negedge clk);
      rd(A_STAT, d);
      check(d[1], 1, "R6 glitch not stored");

      // parity and stop errors
      ctl(3, 1, 0, 0, 1, 1);
      wr(A_CLR, 32'h7F);
      rx_send(8'h3C, 3, 1, 0, 0, 1'b1, 1'b1);
      rd(A_EVT, d);
      check(d[2], 1, "R7 parity error flag");
      rd(A_RXD, d);
      check(d, 32'h3C, "R7 char kept on parity error");
      wr(A_CLR, 32'h7F);
      ctl(3, 0, 0, 0, 1, 1);
      rx_send(8'h81, 3, 0, 0, 0, 1'b0, 1'b0);
      rd(A_EVT, d);
      check(d[1], 1, "R7 stop error flag");
      check(d[2], 0, "R7 no parity flag with parity off");
      rd(A_RXD, d);
      check(d, 32'h81, "R7 char kept on stop error");

      // underrun
      wr(A_CLR, 32'h7F);
      rd(A_RXD, d);
      check(d, 0, "R9 empty read returns zero");
      rd(A_EVT, d);
      check(d[4], 1, "R9 underrun flag");

      // receive overrun
      wr(A_CLR, 32'h7F);
      for (int i = 0; i < 9; i++) rx_send(8'h30 + 8'(i), 3, 0, 0, 0, 1'b0, 1'b1);
      rd(A_STAT, d);
      check(d[0], 1, "R8 rx full after 8");
      rd(A_EVT, d);
      check(d[3], 1, "R8 rx overrun flag");
      for (int i = 0; i < 8; i++) begin
         rd(A_RXD, d);
         check(d, 32'h30 + i, "R8 first eight kept in order");
      end
      rd(A_STAT, d);
      check(d[1], 1, "R8 rx empty after drain");

      // interrupt masking and write-one-to-clear
      wr(A_CLR, 32'h7F);
      wr(A_MASK, 32'h40);
      @(negedge clk);
      check(irq, 0, "R10 irq low with flags clear");
      rx_send(8'h77, 3, 0, 0, 0, 1'b0, 1'b1);
      check(irq, 1, "R10 irq on rx non-empty");
      rd(A_RXD, d);
      @(negedge clk);
      check(irq, 1, "R10 flag sticky after drain");
      wr(A_CLR, 32'h40);
      @(negedge clk);
      check(irq, 0, "R10 irq low after clear");
      rd(A_EVT, d);
      check(d[6], 0, "R10 flag bit 6 cleared");
      wr(A_MASK, 32'h0);

      // transmit overrun and transmitter off
      ctl(3, 0, 0, 0, 1, 0);
      wr(A_CLR, 32'h7F);
      for (int i = 0; i < 9; i++) wr(A_TXD, 32'h40 + i);
      rd(A_STAT, d);
      check(d[2], 1, "R8 tx full after 8");
      rd(A_EVT, d);
      check(d[0], 1, "R8 tx overrun flag");
      lows = 0;
      for (int i = 0; i < 100; i++) begin @(negedge clk); if (!ser_tx) lows++; end
      check(lows, 0, "R11 line high while transmitter off");
      ctl(3, 0, 0, 0, 1, 1);
      wait_start(ok);
      ctl(3, 0, 0, 0, 1, 0);
      if (ok) tx_frame(8'h40, 3, 0, 0, 0, 2);
      lows = 0;
      for (int i = 0; i < 400; i++) begin @(negedge clk); if (!ser_tx) lows++; end
      check(lows, 0, "R11 frame finished then line held high");
      rd(A_STAT, d);
      check(d[3], 0, "R11 remaining chars kept");

      // receiver off mid-frame
      ctl(3, 0, 0, 0, 1, 0);
      @(negedge clk); ser_rx = 1'b0;
      repeat (20) @(negedge clk);
      ctl(3, 0, 0, 0, 0, 0);
      ser_rx = 1'b1; repeat (BIT) @(negedge clk);
      ser_rx = 1'b0; repeat (BIT) @(negedge clk);
      ser_rx = 1'b1; repeat (30) @(negedge clk);
      ctl(3, 0, 0, 0, 1, 0);
      repeat (200) @(negedge clk);
      rd(A_STAT, d);
      check(d[1], 1, "R12 partial frame not stored");
      rx_send(8'hC3, 3, 0, 0, 0, 1'b0, 1'b1);
      rd(A_RXD, d);
      check(d, 32'hC3, "R12 receives after re-enable");

      report();
      $finish;
   end
endmodule